// File: doc/BRIEF.md
# Configurable Delay-Line Context Generator

This block sits in front of a context-based binary arithmetic coder and turns a raster-ordered stream of binary pixels into a 10-bit causal neighbourhood context for each pixel. It handles square blocks 4, 8 or 16 pixels wide. The pixels already seen flow through three chained shift lines of 16 stages each. Taps in the chain select the line length, so the length always matches the block width. Stages above the active length keep their contents.

A block begins with a `start` pulse, which also latches the width. The two rows of border pixels above the block then arrive serially. Their left ends go to dedicated left-border registers, and their right ends beyond the block go to dedicated top-right registers. The middle parts enter the shift chain. After that, the block pixels arrive one at a time, in row order. With the first pixel of each row comes the two-pixel left border of that row.

Each accepted pixel produces one context on the next cycle. Neighbours to the right of the block that are not yet coded are replaced by the rightmost block pixel of the same row.

Top module: `dl_ctx_gen`

## Requirements
- R1: `size_sel` is sampled on the `start` pulse and sets the block width B: 0 gives 4, 1 gives 8, 2 and 3 give 16. Exactly B*B contexts are produced per block.
- R2: After `start`, 2*(B+4) border bits are taken on `bdr_vld`. Row y=-2 comes first, then row y=-1. Within each row the order is x=-2 up to x=B+1. `ctx_vld` stays low throughout this loading.
- R3: For pixel (x,y) the context bits are: bit0 (x-1,y), bit1 (x-2,y), bit2 (x+2,y-1), bit3 (x+1,y-1), bit4 (x,y-1), bit5 (x-1,y-1), bit6 (x-2,y-1), bit7 (x+1,y-2), bit8 (x,y-2), bit9 (x-1,y-2).
- R4: `left_in` is sampled only with the column-0 pixel of a row: bit0 is (-1,y) and bit1 is (-2,y). Its value on any other column has no effect.
- R5: A neighbour at x>=B in a block row (y>=0) takes the value of pixel (B-1) in that row. A neighbour at x>=B in border rows -1 and -2 takes the loaded border bit.
- R6: The effective length of each shift line equals B. Stages above B hold their value.
- R7: `ctx_vld` pulses in the cycle after each accepted pixel. `ctx` holds its value when no pixel is accepted.
- R8: Once B*B pixels have been accepted, `pix_vld` is ignored until the next `start`.
- R9: After reset, `ctx` is 0 and `ctx_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new block and latches the width |
| size_sel | input | 2 | Block width code |
| bdr_vld | input | 1 | Border bit strobe during loading |
| bdr_bit | input | 1 | Serial border bit |
| pix_vld | input | 1 | Block pixel strobe |
| pix_bit | input | 1 | Block pixel value |
| left_in | input | 2 | Left border pair of the current row, used at column 0 |
| ctx | output | 10 | Context of the last accepted pixel |
| ctx_vld | output | 1 | Context valid pulse |

## Verification
Two cases are hard to reach from the ports. The first is the hand-over at the top-right corner: in row 1, column B-1 reads the loaded border bit, and in row 2 the same position reads the stored block pixel. The second is the crossing at column 1, where one left neighbour comes from the left registers and the other comes from the chain. The stimulus reaches both by sweeping every pixel of every block width. It uses border and block patterns from an arithmetic hash, so that neighbouring bits differ. It also feeds junk on `left_in` away from column 0 and inserts idle cycles between pixels, which shows that the output holds.

// File: rtl/dl_ctx_gen.sv
module dl_ctx_gen #(
  parameter int LW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] size_sel,
  input  logic       bdr_vld,
  input  logic       bdr_bit,
  input  logic       pix_vld,
  input  logic       pix_bit,
  input  logic [1:0] left_in,
  output logic [9:0] ctx,
  output logic       ctx_vld
);

  localparam int CW = $clog2(LW + 1);
  localparam int PW = $clog2(LW + 5);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} st_t;

  st_t            st;
  logic [CW-1:0]  bsz, col, row, dec;
  logic [PW-1:0]  pcol;
  logic           prow;
  logic [LW-1:0]  dl0, dl1, dl2, msk, nx0, nx1, nx2, sh0, sh1;
  logic [LW:0]    msk_w;
  logic [1:0]     l_cur, l_p1, r1, r2;
  logic           acc, ld_mid, pl_r0, pl_last, shift, din, tap0, tap1;
  logic [9:0]     ctx_c;

  assign dec = (size_sel == 2'd0) ? CW'(4) : (size_sel == 2'd1) ? CW'(8) : CW'(LW);

  assign acc     = !start && (st == ST_RUN) && pix_vld;
  assign ld_mid  = (int'(pcol) >= 2) && (int'(pcol) < int'(bsz) + 2);
  assign pl_r0   = int'(pcol) == int'(bsz) + 2;
  assign pl_last = int'(pcol) == int'(bsz) + 3;
  assign shift   = acc || (!start && (st == ST_LOAD) && bdr_vld && ld_mid);
  assign din     = (st == ST_RUN) ? pix_bit : bdr_bit;

  assign msk_w = ((LW+1)'(1) << bsz) - (LW+1)'(1);
  assign msk   = msk_w[LW-1:0];
  assign sh0   = dl0 >> (bsz - CW'(1));
  assign sh1   = dl1 >> (bsz - CW'(1));
  assign tap0  = sh0[0];
  assign tap1  = sh1[0];

  assign nx0 = ({dl0[LW-2:0], din } & msk) | (dl0 & ~msk);
  assign nx1 = ({dl1[LW-2:0], tap0} & msk) | (dl1 & ~msk);
  assign nx2 = ({dl2[LW-2:0], tap1} & msk) | (dl2 & ~msk);

  function automatic logic pick(input logic [LW-1:0] a, input logic [LW-1:0] b,
                                input logic [LW-1:0] c, input int n, input int p);
    logic [LW-1:0] t;
    if (p <= n)          t = a >> (p - 1);
    else if (p <= 2 * n) t = b >> (p - n - 1);
    else                 t = c >> (p - 2 * n - 1);
    return t[0];
  endfunction

  always_comb begin
    int n, x, y;
    logic xl, x1, xr, xr2, y0, y1;
    n   = int'(bsz);
    x   = int'(col);
    y   = int'(row);
    xl  = (x == 0);
    x1  = (x == 1);
    xr  = (x == n - 1);
    xr2 = (x == n - 2);
    y0  = (y == 0);
    y1  = (y == 1);
    ctx_c[0] = xl ? left_in[0] : pick(dl0, dl1, dl2, n, 1);
    ctx_c[1] = xl ? left_in[1] : x1 ? l_cur[0] : pick(dl0, dl1, dl2, n, 2);
    ctx_c[2] = xr  ? (y0 ? r1[1] : pick(dl0, dl1, dl2, n, n)) :
               xr2 ? (y0 ? r1[0] : pick(dl0, dl1, dl2, n, n - 1)) :
                     pick(dl0, dl1, dl2, n, n - 2);
    ctx_c[3] = xr ? (y0 ? r1[0] : pick(dl0, dl1, dl2, n, n)) : pick(dl0, dl1, dl2, n, n - 1);
    ctx_c[4] = pick(dl0, dl1, dl2, n, n);
    ctx_c[5] = xl ? l_cur[0] : pick(dl0, dl1, dl2, n, n + 1);
    ctx_c[6] = xl ? l_cur[1] : x1 ? l_p1[0] : pick(dl0, dl1, dl2, n, n + 2);
    ctx_c[7] = xr ? (y0 ? r2[0] : y1 ? r1[0] : pick(dl0, dl1, dl2, n, 2 * n))
                  : pick(dl0, dl1, dl2, n, 2 * n - 1);
    ctx_c[8] = pick(dl0, dl1, dl2, n, 2 * n);
    ctx_c[9] = xl ? l_p1[0] : pick(dl0, dl1, dl2, n, 2 * n + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bsz     <= CW'(LW);
      col     <= '0;
      row     <= '0;
      pcol    <= '0;
      prow    <= 1'b0;
      dl0     <= '0;
      dl1     <= '0;
      dl2     <= '0;
      l_cur   <= '0;
      l_p1    <= '0;
      r1      <= '0;
      r2      <= '0;
      ctx     <= '0;
      ctx_vld <= 1'b0;
    end else begin
      ctx_vld <= acc;
      if (acc) ctx <= ctx_c;
      if (shift) begin
        dl0 <= nx0;
        dl1 <= nx1;
        dl2 <= nx2;
      end
      if (start) begin
        st   <= ST_LOAD;
        bsz  <= dec;
        pcol <= '0;
        prow <= 1'b0;
        col  <= '0;
        row  <= '0;
      end else begin
        case (st)
          ST_LOAD: if (bdr_vld) begin
            if (pcol == '0) begin
              l_p1     <= l_cur;
              l_cur[1] <= bdr_bit;
            end
            if (pcol == PW'(1)) l_cur[0] <= bdr_bit;
            if (pl_r0) begin
              if (prow) r1[0] <= bdr_bit;
              else      r2[0] <= bdr_bit;
            end
            if (pl_last) begin
              if (prow) r1[1] <= bdr_bit;
              else      r2[1] <= bdr_bit;
              pcol <= '0;
              prow <= 1'b1;
              if (prow) st <= ST_RUN;
            end else begin
              pcol <= pcol + PW'(1);
            end
          end
          ST_RUN: if (pix_vld) begin
            if (col == '0) begin
              l_p1  <= l_cur;
              l_cur <= left_in;
            end
            if (col == bsz - CW'(1)) begin
              col <= '0;
              if (row == bsz - CW'(1)) begin
                row <= '0;
                st  <= ST_IDLE;
              end else begin
                row <= row + CW'(1);
              end
            end else begin
              col <= col + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (col < bsz) && (row < bsz));

  a_r2_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD) |=> !ctx_vld);

  a_r6_hold_4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && bsz == CW'(4)) |=>
      $stable(dl0[LW-1:4]) && $stable(dl1[LW-1:4]) && $stable(dl2[LW-1:4]));

  a_r6_hold_8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && bsz == CW'(8)) |=>
      $stable(dl0[LW-1:8]) && $stable(dl1[LW-1:8]) && $stable(dl2[LW-1:8]));

  a_r7_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(ctx));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> !ctx_vld && $stable(dl0) && $stable(dl1));

endmodule

// File: tb/dl_ctx_gen_tb_top.sv
`timescale 1ns/1ps
module dl_ctx_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, start, bdr_vld, bdr_bit, pix_vld, pix_bit;
  logic [1:0] size_sel, left_in;
  logic [9:0] ctx;
  logic       ctx_vld;

  int n_chk = 0, n_fail = 0, cyc = 0, nvld = 0, cur_b = 16;
  logic top_a  [0:1][0:19];
  logic left_a [0:15][0:1];
  logic blk    [0:15][0:15];

  always #4 clk = ~clk;

  dl_ctx_gen #(.LW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .bdr_vld(bdr_vld), .bdr_bit(bdr_bit), .pix_vld(pix_vld), .pix_bit(pix_bit),
    .left_in(left_in), .ctx(ctx), .ctx_vld(ctx_vld));

  always @(negedge clk) if (ctx_vld) nvld++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=%0d expected<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic gen(input int p, input int x, input int y);
    int h;
    h = x * 37 + y * 101 + x * y * 11 + p * 57 + 1000;
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return 1'((x + y) & 1);
      default: return h[3] ^ h[6];
    endcase
  endfunction

  function automatic logic val(input int x, input int y);
    if (y < 0)           return top_a[y+2][x+2];
    else if (x < 0)      return left_a[y][-x-1];
    else if (x >= cur_b) return blk[y][cur_b-1];
    else                 return blk[y][x];
  endfunction

  function automatic logic [9:0] exp_ctx(input int x, input int y);
    return {val(x-1, y-2), val(x, y-2), val(x+1, y-2),
            val(x-2, y-1), val(x-1, y-1), val(x, y-1), val(x+1, y-1), val(x+2, y-1),
            val(x-2, y), val(x-1, y)};
  endfunction

  task automatic run_block(input logic [1:0] sel, input int b, input int p);
    logic [9:0] last, e;
    string tag;
    cur_b = b;
    for (int r = 0; r < 2; r++)
      for (int j = 0; j < b + 4; j++) top_a[r][j] = gen(p, j - 2, r - 2);
    for (int y = 0; y < b; y++) begin
      left_a[y][0] = gen(p, -1, y);
      left_a[y][1] = gen(p, -2, y);
      for (int x = 0; x < b; x++) blk[y][x] = gen(p, x, y);
    end
    start = 1'b1; size_sel = sel;
    @(negedge clk);
    start = 1'b0;
    chk("R2", int'(ctx_vld), 0);
    for (int r = 0; r < 2; r++)
      for (int j = 0; j < b + 4; j++) begin
        bdr_vld = 1'b1; bdr_bit = top_a[r][j];
        @(negedge clk);
        chk("R2", int'(ctx_vld), 0);
      end
    bdr_vld = 1'b0;
    nvld = 0;
    last = ctx;
    for (int y = 0; y < b; y++)
      for (int x = 0; x < b; x++) begin
        if (((x * 3 + y + p) % 5) == 0) begin
          pix_vld = 1'b0;
          @(negedge clk);
          chk("R7", int'(ctx_vld), 0);
          chk("R7", int'(ctx), int'(last));
        end
        pix_vld = 1'b1; pix_bit = blk[y][x];
        left_in = (x == 0) ? {left_a[y][1], left_a[y][0]} : 2'(x * y + p + 1);
        @(negedge clk);
        e = exp_ctx(x, y);
        if (b < 16)           tag = "R6";
        else if (x <= 1)      tag = "R4";
        else if (x >= b - 2)  tag = "R5";
        else                  tag = "R3";
        chk(tag, int'(ctx), int'(e));
        chk("R7", int'(ctx_vld), 1);
        last = e;
      end
    pix_vld = 1'b0;
    @(negedge clk);
    chk("R7", int'(ctx_vld), 0);
    for (int k = 0; k < 2; k++) begin
      pix_vld = 1'b1; pix_bit = 1'b1;
      @(negedge clk);
      chk("R8", int'(ctx_vld), 0);
      chk("R8", int'(ctx), int'(last));
    end
    pix_vld = 1'b0;
    chk("R1", nvld, b * b);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; size_sel = 2'd0; bdr_vld = 1'b0; bdr_bit = 1'b0;
    pix_vld = 1'b0; pix_bit = 1'b0; left_in = 2'd0;
    repeat (3) @(negedge clk);
    chk("R9", int'(ctx), 0);
    chk("R9", int'(ctx_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pix_vld = 1'b1;
    @(negedge clk);
    chk("R8", int'(ctx_vld), 0);
    pix_vld = 1'b0;
    for (int p = 0; p < 5; p++) begin
      run_block(2'd0, 4, p);
      run_block(2'd1, 8, p);
      run_block(2'd2, 16, p);
    end
    run_block(2'd3, 16, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule